// File: doc/BRIEF.md
# Hybrid-Format Microprogram Sequencer

This block is the control heart of a microcoded processor. It keeps a 256-entry store of 32-bit microwords. Each cycle it reads the word addressed by its microprogram counter and turns that word into 40 registered micro-command lines.

Nine of those lines are copied straight from dedicated bits of the word. The remaining 31 come from four small encoded fields. Each field selects at most one command out of a mutually exclusive group of 7, 16, 3 or 5 commands, and each field reserves code zero for "nothing".

A 2-bit selector in the same word picks how the counter advances. It can jump to the word's 8-bit next-address field, or fold one of two external test inputs into the lowest bit of that field, or take an entry address supplied from outside. The last option is used to dispatch on an opcode. Software or a boot engine fills the store through a write port while the sequencer is stopped.

Top module: `mseq_top`

## Requirements
- R1: While `rst` is high at a rising edge, `upc_o` becomes 0 and `cmd_o` becomes all zeros.
- R2: When `run_en` is high at an edge, `cmd_o[i]` for i in 0..8 takes bit 23+i of the word stored at the current `upc_o`. The new value is visible after that edge.
- R3: Group A uses word bits [22:20]. Code k from 1 to 7 sets `cmd_o[9+k-1]` alone among `cmd_o[15:9]`. Code 0 sets none of them.
- R4: Group B uses word bits [19:15]. Code k from 1 to 16 sets `cmd_o[16+k-1]` alone among `cmd_o[31:16]`. Codes 0 and 17 to 31 set none of them.
- R5: Group C uses word bits [14:13]. Code k from 1 to 3 sets `cmd_o[32+k-1]`. Code 0 sets none of `cmd_o[34:32]`.
- R6: Group D uses word bits [12:10]. Code k from 1 to 5 sets `cmd_o[35+k-1]`. Codes 0, 6 and 7 set none of `cmd_o[39:35]`.
- R7: With selector bits [9:8] equal to 00, the next `upc_o` equals word bits [7:0].
- R8: With selector 01, the next `upc_o` is word bits [7:0] with `cond_in[0]` ORed into bit 0. With selector 10, `cond_in[1]` is ORed into bit 0 instead.
- R9: With selector 11, the next `upc_o` equals `entry_addr`.
- R10: While `run_en` is low, `upc_o` holds its value and `cmd_o` is all zeros one edge later.
- R11: A store write (`wr_en`, `wr_addr`, `wr_data`) takes effect only when `run_en` is low at the edge. While `run_en` is high the write has no effect.
- R12: Within each encoded group, at most one command line is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Sequencer advances while high; store writes are blocked while high |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | 8 | Store write address |
| wr_data | input | 32 | Microword to write |
| entry_addr | input | 8 | Dispatch target used by selector 11 |
| cond_in | input | 2 | External test inputs |
| upc_o | output | 8 | Microprogram counter |
| cmd_o | output | 40 | Registered micro-command lines |

## Verification
The bench builds the block with its default geometry: an 8-bit next-address field and the 9/7/16/3/5 command split. At that size the whole store can be addressed, and every group's top code and its unused codes can be encoded in one short program. The program visits all four selector values, with each test input both true and false. It also includes a dispatch, a stop and resume, and a write attempted during a run to an address that is executed later.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    parameter int MW_W     = 32;
    parameter int DIRECT_N = 9;
    parameter int NGRP     = 4;
    parameter int SEL_W    = 2;
    parameter int NA_W     = 8;
    parameter int CMD_N    = 40;
    parameter int DEPTH    = 1 << NA_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_JUMP     = 2'd0,
        SEL_TEST0    = 2'd1,
        SEL_TEST1    = 2'd2,
        SEL_DISPATCH = 2'd3
    } nsel_e;

    function automatic int grp_code_w(input int g);
        case (g)
            0: return 3;
            1: return 5;
            2: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int grp_size(input int g);
        case (g)
            0: return 7;
            1: return 16;
            2: return 3;
            default: return 5;
        endcase
    endfunction

    // lowest word bit of group g's code field (groups are packed after the direct bits)
    function automatic int grp_code_lsb(input int g);
        int p;
        p = NA_W + SEL_W;
        for (int j = NGRP - 1; j > g; j--) p += grp_code_w(j);
        return p;
    endfunction

    // first command line of group g
    function automatic int grp_cmd_lsb(input int g);
        int p;
        p = DIRECT_N;
        for (int j = 0; j < g; j++) p += grp_size(j);
        return p;
    endfunction

    localparam int CODES_W = MW_W - DIRECT_N - SEL_W - NA_W;

    typedef struct packed {
        logic [DIRECT_N-1:0] direct;
        logic [CODES_W-1:0]  codes;
        nsel_e               sel;
        logic [NA_W-1:0]     nxt;
    } uword_t;
endpackage

// File: rtl/mseq_store.sv
module mseq_store
    import mseq_pkg::*;
(
    input  logic            clk,
    input  logic            wr_ok,
    input  logic [NA_W-1:0] wr_addr,
    input  logic [MW_W-1:0] wr_data,
    input  logic [NA_W-1:0] rd_addr,
    output logic [MW_W-1:0] rd_data
);
    logic [MW_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mseq_field_dec.sv
module mseq_field_dec #(
    parameter int CODE_W = 3,
    parameter int N      = 7
) (
    input  logic [CODE_W-1:0] code,
    output logic [N-1:0]      lines
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign lines[i] = (code == CODE_W'(i + 1));
    end
endmodule

// File: rtl/mseq_next.sv
module mseq_next
    import mseq_pkg::*;
(
    input  nsel_e           sel,
    input  logic [NA_W-1:0] nxt,
    input  logic [1:0]      cond_in,
    input  logic [NA_W-1:0] entry_addr,
    output logic [NA_W-1:0] next_addr
);
    always_comb begin
        unique case (sel)
            SEL_JUMP:     next_addr = nxt;
            SEL_TEST0:    next_addr = nxt | NA_W'(cond_in[0]);
            SEL_TEST1:    next_addr = nxt | NA_W'(cond_in[1]);
            default:      next_addr = entry_addr;
        endcase
    end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             wr_en,
    input  logic [NA_W-1:0]  wr_addr,
    input  logic [MW_W-1:0]  wr_data,
    input  logic [NA_W-1:0]  entry_addr,
    input  logic [1:0]       cond_in,
    output logic [NA_W-1:0]  upc_o,
    output logic [CMD_N-1:0] cmd_o
);
    logic [NA_W-1:0]  upc_q;
    logic [MW_W-1:0]  cur_word;
    uword_t           uw;
    logic [NA_W-1:0]  next_addr;
    logic [CMD_N-1:0] cmd_d;
    logic [CMD_N-1:0] cmd_q;

    mseq_store u_store (
        .clk     (clk),
        .wr_ok   (wr_en && !run_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (upc_q),
        .rd_data (cur_word)
    );

    assign uw = uword_t'(cur_word);

    mseq_next u_next (
        .sel        (uw.sel),
        .nxt        (uw.nxt),
        .cond_in    (cond_in),
        .entry_addr (entry_addr),
        .next_addr  (next_addr)
    );

    assign cmd_d[DIRECT_N-1:0] = uw.direct;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int CW = grp_code_w(g);
        localparam int GN = grp_size(g);
        localparam int CL = grp_code_lsb(g);
        localparam int OL = grp_cmd_lsb(g);
        mseq_field_dec #(.CODE_W(CW), .N(GN)) u_dec (
            .code  (cur_word[CL +: CW]),
            .lines (cmd_d[OL +: GN])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upc_q <= '0;
            cmd_q <= '0;
        end else if (run_en) begin
            upc_q <= next_addr;
            cmd_q <= cmd_d;
        end else begin
            cmd_q <= '0;
        end
    end

    assign upc_o = upc_q;
    assign cmd_o = cmd_q;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk
    import mseq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic [NA_W-1:0]  entry_addr,
    input logic [1:0]       cond_in,
    input logic [NA_W-1:0]  upc_o,
    input logic [CMD_N-1:0] cmd_o,
    input logic [MW_W-1:0]  cur_word
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (upc_o == '0 && cmd_o == '0)); // R1

    AST_DIRECT_COPY: assert property (@(posedge clk) disable iff (rst)
        run_en |=> cmd_o[DIRECT_N-1:0] == $past(cur_word[MW_W-1 -: DIRECT_N])); // R2

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (run_en && cur_word[NA_W +: SEL_W] == 2'b00) |=> upc_o == $past(cur_word[NA_W-1:0])); // R7

    AST_DISPATCH_TARGET: assert property (@(posedge clk) disable iff (rst)
        (run_en && cur_word[NA_W +: SEL_W] == 2'b11) |=> upc_o == $past(entry_addr)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> ($stable(upc_o) && cmd_o == '0)); // R10

    for (genvar g = 0; g < NGRP; g++) begin : g_excl
        AST_GROUP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
            $onehot0(cmd_o[grp_cmd_lsb(g) +: grp_size(g)])); // R12
    end
endmodule

bind mseq_top mseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .entry_addr (entry_addr),
    .cond_in    (cond_in),
    .upc_o      (upc_o),
    .cmd_o      (cmd_o),
    .cur_word   (cur_word)
);

// File: tb/mseq_top_bench.sv
module mseq_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  entry_addr = '0;
    logic [1:0]  cond_in = '0;
    logic [7:0]  upc_o;
    logic [39:0] cmd_o;

    always #2 clk = ~clk;   // 250 MHz

    mseq_top u_mseq_top (
        .clk(clk), .rst(rst), .run_en(run_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .entry_addr(entry_addr),
        .cond_in(cond_in), .upc_o(upc_o), .cmd_o(cmd_o)
    );

    typedef struct {
        logic [7:0]  upc;
        logic [39:0] cmd;
        string       utag;
        string       ctag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          fails  = 0;
    logic [31:0] mdl [256];
    logic [7:0]  mupc;

    function automatic logic [31:0] mk(input logic [8:0] d, input int a, input int b,
                                       input int c, input int e, input int s, input int n);
        return {d, 3'(a), 5'(b), 2'(c), 3'(e), 2'(s), 8'(n)};
    endfunction

    function automatic logic [39:0] dec(input logic [31:0] w);
        logic [39:0] o;
        int k;
        o = '0;
        o[8:0] = w[31:23];
        k = int'(w[22:20]); if (k >= 1 && k <= 7)  o[9 + k - 1]  = 1'b1;   // R3
        k = int'(w[19:15]); if (k >= 1 && k <= 16) o[16 + k - 1] = 1'b1;   // R4
        k = int'(w[14:13]); if (k >= 1 && k <= 3)  o[32 + k - 1] = 1'b1;   // R5
        k = int'(w[12:10]); if (k >= 1 && k <= 5)  o[35 + k - 1] = 1'b1;   // R6
        return o;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues what must appear after the edge
    task automatic step(input bit run, input logic [1:0] cnd, input logic [7:0] ent,
                        input bit we, input logic [7:0] wa, input logic [31:0] wd);
        exp_t        e;
        logic [31:0] w;
        logic [7:0]  nx;
        run_en = run; cond_in = cnd; entry_addr = ent;
        wr_en = we; wr_addr = wa; wr_data = wd;
        if (run) begin
            w = mdl[mupc];
            e.cmd = dec(w);
            e.ctag = "R2 R3 R4 R5 R6";
            case (w[9:8])
                2'b00: begin nx = w[7:0];              e.utag = "R7"; end
                2'b01: begin nx = w[7:0] | {7'd0, cnd[0]}; e.utag = "R8"; end
                2'b10: begin nx = w[7:0] | {7'd0, cnd[1]}; e.utag = "R8"; end
                default: begin nx = ent;               e.utag = "R9"; end
            endcase
        end else begin
            nx = mupc; e.cmd = '0; e.utag = "R10"; e.ctag = "R10";
            if (we) mdl[wa] = wd;                       // R11: only written while stopped
        end
        e.upc = nx;
        @(posedge clk);
        q.push_back(e);
        mupc = nx;
        #1;
    endtask

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.utag, 64'(upc_o), 64'(e.upc));
            check(e.ctag, 64'(cmd_o), 64'(e.cmd));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 upc", 64'(upc_o), 64'd0);
        check("R1 cmd", 64'(cmd_o), 64'd0);
        mupc = 8'h00;
        @(posedge clk); #1;

        // load program while stopped
        step(0, 2'b00, 8'h00, 1, 8'h00, mk(9'h1FF, 1, 16, 3, 5, 0, 8'h10));
        step(0, 2'b00, 8'h00, 1, 8'h10, mk(9'h055, 7, 1, 1, 1, 1, 8'h20));
        step(0, 2'b00, 8'h00, 1, 8'h21, mk(9'h0AA, 0, 17, 2, 6, 2, 8'h30)); // R4 R6 unused codes
        step(0, 2'b00, 8'h00, 1, 8'h30, mk(9'h000, 4, 31, 0, 7, 2, 8'h40));
        step(0, 2'b00, 8'h00, 1, 8'h41, mk(9'h101, 3, 8, 0, 2, 3, 8'h00));
        step(0, 2'b00, 8'h00, 1, 8'h80, mk(9'h0F0, 2, 12, 1, 4, 1, 8'h06));
        step(0, 2'b00, 8'h00, 1, 8'h06, mk(9'h100, 0, 0, 0, 3, 0, 8'h00));

        // run: 0 -> 10 -> 21 -> 30 -> 41 -> 80 -> 06 -> 0
        step(1, 2'b00, 8'h00, 0, 8'h00, '0);                 // R7 jump
        step(1, 2'b01, 8'h00, 0, 8'h00, '0);                 // R8 cond0 true
        step(1, 2'b01, 8'h00, 0, 8'h00, '0);                 // R8 cond1 false
        step(1, 2'b10, 8'h00, 0, 8'h00, '0);                 // R8 cond1 true
        step(1, 2'b00, 8'h80, 0, 8'h00, '0);                 // R9 dispatch
        step(1, 2'b10, 8'h00, 1, 8'h06, 32'hFFFF_FFFF);      // R8 cond0 false; R11 write ignored
        step(1, 2'b00, 8'h00, 0, 8'h00, '0);                 // executes 06: R11 word unchanged

        // stop and resume
        step(0, 2'b11, 8'h55, 0, 8'h00, '0);                 // R10
        step(0, 2'b11, 8'h55, 0, 8'h00, '0);                 // R10
        for (int i = 0; i < 12; i++)
            step(1, 2'(i), 8'h80, 0, 8'h00, '0);

        step(0, 2'b00, 8'h00, 0, 8'h00, '0);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule